// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block turns a 32768 Hz enable strobe into a programmable periodic tick for a real-time-clock style timer. A free-running strobe counter advances once per strobe; a 4-bit rate code selects a power-of-two period, and a tick occurs whenever the counter lands on a multiple of that period. Ticks are therefore locked to the counter, not to the moment software programs a new rate.

Each tick sets a sticky periodic flag. If the periodic-interrupt enable is on, it also raises an interrupt request. If the square-wave enable is on, it emits a single-cycle pulse. The flag and the request stay up until a clear strobe arrives; that strobe stands for a read of the status register. A divider-hold control forces the counter to zero and suppresses ticks while it is active.

Top module: `periodic_tick_gen`

## Requirements
- R1: While reset is applied, and after it is released, `tick_flag`, `irq_req` and `sqw_pulse` are 0 and the strobe counter is 0.
- R2: A rate code of 0 produces no tick, whatever the enables are: no flag, no request and no pulse.
- R3: Rate codes 1 and 2 alias to codes 8 and 9, giving periods of 128 and 256 strobes.
- R4: For rate codes 3 to 15 the period is 2^(code-1) strobes, from 4 strobes at code 3 up to 16384 strobes at code 15. Cycles without a strobe do not count.
- R5: Ticks occur only when the rate code is nonzero and at least one of `pie_en` and `sqw_en` is 1.
- R6: A tick occurs on the strobe that brings the free-running 15-bit counter to a multiple of the current period. After a new code is programmed, the first tick comes at the next such multiple, not one full period later.
- R7: Each tick sets `tick_flag` one clock after the strobe edge. The flag stays set until `flag_clr` is high at a clock edge. A tick on that same edge keeps the flag set.
- R8: `irq_req` is set by a tick only when `pie_en` is 1, and it is cleared by `flag_clr` together with the flag.
- R9: When `sqw_en` is 1, each tick gives exactly one clock of `sqw_pulse`. When `sqw_en` is 0, no pulse is produced.
- R10: While `div_hold` is 1 the counter is held at 0 and no tick occurs. After release, the first tick comes after exactly one period of strobes.
- R11: A rate change takes effect at the next boundary of the new period, counted on the same free-running counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_stb | input | 1 | One-cycle strobe at the 32768 Hz base rate |
| rate_code | input | 4 | Period select code |
| pie_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| div_hold | input | 1 | Holds the strobe counter at zero |
| flag_clr | input | 1 | Clears flag and request (status read) |
| tick_flag | output | 1 | Sticky periodic flag |
| irq_req | output | 1 | Interrupt request |
| sqw_pulse | output | 1 | One-cycle pulse per tick |

## Verification
The bench sweeps every rate code from a held-zero counter and counts the pulses. A wrong alias for codes 1 and 2, or a period that is off by one power of two, shows up as the wrong number of pulses. Programming a code at a misaligned count, and switching rates in mid-run, exposes a design that restarts the period at programming time: its first pulse arrives a full period late instead of at the next multiple. Further runs cover strobe gaps, a held divider, and each enable used alone. They catch pulses that leak out with `sqw_en` low, requests raised without `pie_en`, and a flag that drops without a clear.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  // Codes at or below this limit are moved up by the step below.
  localparam int PTG_ALIAS_LIMIT = 2;
  localparam int PTG_ALIAS_STEP  = 7;

  typedef struct packed {
    logic flag;
    logic irq;
    logic pulse;
  } ptg_out_t;

  // log2 of the period for a nonzero code; code 0 gives 0 and is gated elsewhere.
  function automatic int ptg_shift(input int code);
    int eff;
    if (code == 0) return 0;
    eff = (code <= PTG_ALIAS_LIMIT) ? code + PTG_ALIAS_STEP : code;
    return eff - 1;
  endfunction
endpackage

// File: rtl/ptg_rst_sync.sv
module ptg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ptg_timebase.sv
module ptg_timebase #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_stb,
  input  logic             div_hold,
  output logic [CNT_W-1:0] cnt_nx,
  output logic             advance
);
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_en;

  always_comb begin
    advance = base_stb & ~div_hold;
    cnt_en  = advance | div_hold;
    if (div_hold) cnt_nx = '0;
    else          cnt_nx = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/ptg_rate_decode.sv
module ptg_rate_decode
  import ptg_pkg::*;
#(
  parameter int RATE_W = 4,
  parameter int CNT_W  = 15
) (
  input  logic [RATE_W-1:0] rate_code,
  input  logic              pie_en,
  input  logic              sqw_en,
  output logic              active,
  output logic [CNT_W-1:0]  align_mask
);
  int shift_amt;

  always_comb begin
    shift_amt = ptg_shift(int'(rate_code));
    active    = (rate_code != '0) && (pie_en || sqw_en);
  end

  // Low shift_amt bits of the counter must be zero on a boundary.
  for (genvar gi = 0; gi < CNT_W; gi++) begin : g_mask
    assign align_mask[gi] = (gi < shift_amt);
  end
endmodule

// File: rtl/ptg_event_regs.sv
module ptg_event_regs
  import ptg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     boundary,
  input  logic     pie_en,
  input  logic     sqw_en,
  input  logic     flag_clr,
  output ptg_out_t ev_q
);
  ptg_out_t ev_d;

  always_comb begin
    ev_d = ev_q;
    if (flag_clr) begin
      ev_d.flag = 1'b0;
      ev_d.irq  = 1'b0;
    end
    if (boundary) begin
      ev_d.flag = 1'b1;
      if (pie_en) ev_d.irq = 1'b1;
    end
    ev_d.pulse = boundary & sqw_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_d;
  end
endmodule

// File: rtl/periodic_tick_gen.sv
module periodic_tick_gen
  import ptg_pkg::*;
#(
  parameter int RATE_W = 4,
  parameter int CNT_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_stb,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              pie_en,
  input  logic              sqw_en,
  input  logic              div_hold,
  input  logic              flag_clr,
  output logic              tick_flag,
  output logic              irq_req,
  output logic              sqw_pulse
);
  logic             rst_n_int;
  logic [CNT_W-1:0] cnt_nx;
  logic             advance;
  logic             active;
  logic [CNT_W-1:0] align_mask;
  logic             boundary;
  ptg_out_t         ev_q;

  ptg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  ptg_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n_int), .base_stb(base_stb), .div_hold(div_hold),
    .cnt_nx(cnt_nx), .advance(advance)
  );

  ptg_rate_decode #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_dec (
    .rate_code(rate_code), .pie_en(pie_en), .sqw_en(sqw_en),
    .active(active), .align_mask(align_mask)
  );

  assign boundary = advance & active & ~|(cnt_nx & align_mask);

  ptg_event_regs u_ev (
    .clk(clk), .rst_n(rst_n_int), .boundary(boundary), .pie_en(pie_en),
    .sqw_en(sqw_en), .flag_clr(flag_clr), .ev_q(ev_q)
  );

  assign tick_flag = ev_q.flag;
  assign irq_req   = ev_q.irq;
  assign sqw_pulse = ev_q.pulse;
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
  parameter int RATE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [RATE_W-1:0] rate_code,
  input logic              pie_en,
  input logic              sqw_en,
  input logic              div_hold,
  input logic              flag_clr,
  input logic              tick_flag,
  input logic              irq_req,
  input logic              sqw_pulse
);
  // R2
  p_no_tick_code0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_flag) |-> $past(rate_code) != '0);
  // R5
  p_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_flag) |-> ($past(pie_en) || $past(sqw_en)));
  // R7
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_flag && !flag_clr) |=> tick_flag);
  // R8
  p_irq_needs_pie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(pie_en));
  p_irq_under_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> tick_flag);
  // R9
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |=> !sqw_pulse);
  p_pulse_needs_sqw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |-> $past(sqw_en));
  // R10
  p_hold_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    div_hold |=> !sqw_pulse);
endmodule

bind periodic_tick_gen ptg_checker #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .pie_en(pie_en),
  .sqw_en(sqw_en), .div_hold(div_hold), .flag_clr(flag_clr),
  .tick_flag(tick_flag), .irq_req(irq_req), .sqw_pulse(sqw_pulse)
);

// File: tb/sim_periodic_tick_gen.sv
module sim_periodic_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 190000;

  logic       clk;
  logic       rst_n;
  logic       base_stb;
  logic [3:0] rate_code;
  logic       pie_en, sqw_en, div_hold, flag_clr;
  logic       tick_flag, irq_req, sqw_pulse;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  bit    done  = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";

  periodic_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .base_stb(base_stb), .rate_code(rate_code),
    .pie_en(pie_en), .sqw_en(sqw_en), .div_hold(div_hold), .flag_clr(flag_clr),
    .tick_flag(tick_flag), .irq_req(irq_req), .sqw_pulse(sqw_pulse)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Arithmetic reference built from the requirements.
  int m_cnt;
  bit m_flag, m_irq, m_pulse;

  function automatic int period_of(input int code);
    int eff;
    eff = (code <= 2) ? code + 7 : code;
    return 1 << (eff - 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_flag <= 0; m_irq <= 0; m_pulse <= 0;
    end else begin
      bit tk;
      int n;
      tk = 0;
      n  = m_cnt;
      if (div_hold) n = 0;
      else if (base_stb) begin
        n  = (m_cnt + 1) % 32768;
        tk = (rate_code != 0) && (pie_en || sqw_en) &&
             (n % period_of(int'(rate_code)) == 0);
      end
      m_cnt   <= n;
      m_pulse <= tk && sqw_en;
      if (tk) begin
        m_flag <= 1;
        if (pie_en) m_irq <= 1;
        else if (flag_clr) m_irq <= 0;
      end else if (flag_clr) begin
        m_flag <= 0; m_irq <= 0;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done)
      chk(cur_req, "outputs {flag,irq,pulse}", {tick_flag, irq_req, sqw_pulse},
          {m_flag, m_irq, m_pulse});
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_LIMIT && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG_LIMIT);
      finish_run();
    end
  end

  task automatic hold_zero();
    base_stb = 0; div_hold = 1;
    repeat (2) @(negedge clk);
    div_hold = 0;
  endtask

  task automatic clear_flag();
    flag_clr = 1; @(negedge clk); flag_clr = 0;
  endtask

  // n consecutive strobes, returns pulses seen.
  task automatic run(input int n, output int pulses);
    pulses = 0;
    base_stb = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sqw_pulse) pulses++;
    end
    base_stb = 0;
  endtask

  // strobes until the first pulse, returns that strobe index (0 if none).
  task automatic until_pulse(input int max, output int k);
    k = 0;
    base_stb = 1;
    for (int i = 1; i <= max; i++) begin
      @(negedge clk);
      if (sqw_pulse) begin k = i; break; end
    end
    base_stb = 0;
  endtask

  initial begin
    int p, k;
    rst_n = 0; base_stb = 0; rate_code = 0; pie_en = 0; sqw_en = 0;
    div_hold = 0; flag_clr = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "outputs in reset", {tick_flag, irq_req, sqw_pulse}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "outputs after reset", {tick_flag, irq_req, sqw_pulse}, 0);
    cmp_on = 1;

    // R2: code 0 silent with both enables on
    cur_req = "R2";
    rate_code = 0; pie_en = 1; sqw_en = 1;
    run(300, p);
    chk("R2", "pulses at code 0", p, 0);
    chk("R2", "flag at code 0", tick_flag, 0);

    // R3 / R4: sweep every code from a zeroed counter
    pie_en = 0;
    for (int c = 1; c < 16; c++) begin
      cur_req = (c <= 2) ? "R3" : "R4";
      clear_flag();
      hold_zero();
      rate_code = 4'(c);
      run(2 * period_of(c) + 3, p);
      chk(cur_req, $sformatf("pulses code %0d", c), p, 2);
    end
    // R7: flag still set long after the last tick with no clear
    cur_req = "R7";
    rate_code = 0;
    repeat (20) @(negedge clk);
    chk("R7", "flag sticky", tick_flag, 1);
    chk("R8", "irq with pie off", irq_req, 0);
    clear_flag();
    @(negedge clk);
    chk("R7", "flag after clear", tick_flag, 0);

    // R5: both enables off
    cur_req = "R5";
    hold_zero();
    rate_code = 3; pie_en = 0; sqw_en = 0;
    run(100, p);
    chk("R5", "flag with enables off", tick_flag, 0);

    // R8: periodic interrupt only, no pulse
    cur_req = "R8";
    hold_zero();
    rate_code = 4; pie_en = 1; sqw_en = 0;
    run(40, p);
    chk("R9", "pulses with sqw off", p, 0);
    chk("R8", "irq with pie on", irq_req, 1);
    chk("R8", "flag with pie on", tick_flag, 1);
    pie_en = 0;
    clear_flag();
    chk("R8", "irq after clear", irq_req, 0);
    chk("R7", "flag after clear", tick_flag, 0);

    // R6: program at a misaligned count
    cur_req = "R6";
    sqw_en = 1;
    hold_zero();
    rate_code = 0;
    run(37, p);
    rate_code = 5;
    until_pulse(100, k);
    chk("R6", "strobes to first tick after programming at 37", k, 11);

    // R11: rate changes mid-run
    cur_req = "R11";
    hold_zero();
    rate_code = 6;
    run(20, p);
    chk("R11", "no pulse before first boundary", p, 0);
    rate_code = 3;
    until_pulse(100, k);
    chk("R11", "strobes to tick after switch to period 4", k, 4);
    rate_code = 8;
    until_pulse(300, k);
    chk("R11", "strobes to tick after switch to period 128", k, 104);

    // R10: held divider
    cur_req = "R10";
    hold_zero();
    rate_code = 3;
    run(10, p);
    chk("R10", "pulses before hold", p, 2);
    div_hold = 1; base_stb = 1;
    p = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (sqw_pulse) p++;
    end
    div_hold = 0; base_stb = 0;
    chk("R10", "pulses during hold", p, 0);
    until_pulse(20, k);
    chk("R10", "strobes to tick after release", k, 4);

    // R4: gapped strobes count only when present
    cur_req = "R4";
    hold_zero();
    rate_code = 4;
    p = 0;
    for (int i = 0; i < 64; i++) begin
      base_stb = i[0];
      @(negedge clk);
      if (sqw_pulse) p++;
    end
    base_stb = 0;
    @(negedge clk);
    if (sqw_pulse) p++;
    chk("R4", "pulses with strobe every other cycle", p, 4);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule